// File: doc/BRIEF.md
# Dual-Order Serial Register Port

This block is the slave side of a four-wire serial control link. A host microcontroller uses it to read and write a small internal register file. The host pulls chip select low and sends one command byte. That byte carries a direction flag and a register address. Then, until chip select rises again, every byte that follows is a data byte for that same address.

A static bit-order input selects how bytes travel on the wire:
- Least-significant bit first.
- Most-significant bit first.

The serial pins are sampled by the block's own system clock. Edges of the serial clock are found by comparing each sample with the one before it. This keeps the whole block in a single clock domain.

The link has no data stream at the block edge, so there is no valid/ready handshake. Pacing is set entirely by the host's serial clock, and the block cannot apply back-pressure.

Read data leaves on `sdo`, together with an enable that tells the pad when to drive it.

Top module: `serctl_port`

## Requirements
- R1: While `cs_n` is low, `sdi` is captured on each rising edge of `sclk`. With `msb_first`=0 the first captured bit is byte bit 0; with `msb_first`=1 the first captured bit is byte bit 7.
- R2: The first complete byte after `cs_n` falls is decoded as a command. The read flag is the first bit on the wire (byte bit 0 when `msb_first`=0, byte bit 7 when `msb_first`=1), and 1 means read. The address is byte bits 7:5 when `msb_first`=0 and byte bits 2:0 when `msb_first`=1. The remaining four bits are ignored.
- R3: In a write window, each completed data byte is stored into the addressed register.
- R4: In a read window, `sdo` shows the addressed register in the selected bit order. Each bit changes only on a falling `sclk` edge, starting with the first falling edge after the command byte completes.
- R5: `sdo_oe` is 1 only while `cs_n` is low, the command byte has completed, and its read flag was set. It is 0 during the command byte, in write windows and while `cs_n` is high, and `sdo` is 0 whenever `sdo_oe` is 0.
- R6: Every data byte in a window uses the command's address. Repeated reads return the same register, and repeated writes overwrite it, so the last byte wins.
- R7: No byte after the first in a window is treated as a command; a new command needs `cs_n` to go high and then low.
- R8: If `cs_n` rises before a byte's eighth bit, that partial byte is dropped and no register changes.
- R9: After reset every register holds 0, and `sdo_oe` and `sdo` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| msb_first | input | 1 | Bit order: 1 sends bit 7 first, 0 sends bit 0 first |
| cs_n | input | 1 | Active-low chip select framing one transaction |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data toward the host |
| sdo_oe | output | 1 | Drive enable for the `sdo` pad |

## Verification
The assertions assume that the serial pins are already synchronous to `clk` and that each `sclk` level lasts for at least one system clock. They also assume that `msb_first` does not change while `cs_n` is low.

The stimulus meets these assumptions as follows:
- All serial pins change only on falling system-clock edges.
- Each `sclk` phase is held for several system clocks.
- The bit order is changed only between windows, while chip select is high.

Read results are gathered one byte at a time on rising `sclk`, in the selected order. They are compared against values the bench predicts from its earlier writes.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  typedef enum logic {
    ORDER_LSB = 1'b0,
    ORDER_MSB = 1'b1
  } bit_order_e;

  // assemble the next shift value with the new bit placed per order
  function automatic logic [7:0] shift_in8(input logic [7:0] cur, input logic bit_in,
                                           input bit_order_e ord);
    return (ord == ORDER_MSB) ? {cur[6:0], bit_in} : {bit_in, cur[7:1]};
  endfunction
endpackage

// File: rtl/serctl_edge.sv
module serctl_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise = ~cs_n &  sclk & ~sclk_q;
  assign fall = ~cs_n & ~sclk &  sclk_q;
endmodule

// File: rtl/serctl_rx_frame.sv
module serctl_rx_frame
  import serctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rise,
  input  logic              sdi,
  input  bit_order_e        order,
  output logic              byte_done,
  output logic              is_cmd,
  output logic [DATA_W-1:0] byte_val
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              cmd_seen;

  always_comb begin
    if (order == ORDER_MSB) byte_val = {sh[DATA_W-2:0], sdi};
    else                    byte_val = {sdi, sh[DATA_W-1:1]};
  end

  assign byte_done = rise & (cnt == LAST);
  assign is_cmd    = ~cmd_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      cnt      <= '0;
      cmd_seen <= 1'b0;
    end else if (cs_n) begin
      cnt      <= '0;
      cmd_seen <= 1'b0;
    end else if (rise) begin
      sh <= byte_val;
      if (cnt == LAST) begin
        cnt      <= '0;
        cmd_seen <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // bit counter moves only on a captured bit or while deselected
  assert_count_on_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !cs_n) |=> $stable(cnt));
endmodule

// File: rtl/serctl_regfile.sv
module serctl_regfile #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] mem;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    mem[g] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(g))       mem[g] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

  assert_write_needs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem));
endmodule

// File: rtl/serctl_tx.sv
module serctl_tx
  import serctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              fall,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  bit_order_e        order,
  output logic              sdo_q
);
  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      sdo_q <= 1'b0;
    end else if (cs_n) begin
      sdo_q <= 1'b0;
    end else if (load) begin
      sh <= load_data;
    end else if (fall) begin
      if (order == ORDER_MSB) begin
        sdo_q <= sh[DATA_W-1];
        sh    <= {sh[DATA_W-2:0], 1'b0};
      end else begin
        sdo_q <= sh[0];
        sh    <= {1'b0, sh[DATA_W-1:1]};
      end
    end
  end

  assert_sdo_moves_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !cs_n) |=> $stable(sdo_q));
endmodule

// File: rtl/serctl_port.sv
module serctl_port
  import serctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic msb_first,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);
  bit_order_e        order;
  logic              rise, fall;
  logic              byte_done, is_cmd;
  logic [DATA_W-1:0] byte_val;
  logic              dec_rd;
  logic [ADDR_W-1:0] dec_addr;
  logic              rd_q, cmd_done;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              wr_en, tx_load, sdo_q;
  logic              cmd_byte_done;

  assign order = bit_order_e'(msb_first);

  serctl_edge u_edge (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .rise(rise), .fall(fall)
  );

  serctl_rx_frame #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rise(rise), .sdi(sdi), .order(order),
    .byte_done(byte_done), .is_cmd(is_cmd), .byte_val(byte_val)
  );

  // command decode: read flag is the first bit on the wire, address the last ones
  assign dec_rd   = (order == ORDER_MSB) ? byte_val[DATA_W-1] : byte_val[0];
  assign dec_addr = (order == ORDER_MSB) ? byte_val[ADDR_W-1:0]
                                         : byte_val[DATA_W-1 -: ADDR_W];

  assign cmd_byte_done = byte_done & is_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= 1'b0;
      cmd_done <= 1'b0;
      addr_q   <= '0;
    end else if (cs_n) begin
      cmd_done <= 1'b0;
      rd_q     <= 1'b0;
    end else if (cmd_byte_done) begin
      cmd_done <= 1'b1;
      rd_q     <= dec_rd;
      addr_q   <= dec_addr;
    end
  end

  assign rd_addr = cmd_byte_done ? dec_addr : addr_q;
  assign wr_en   = byte_done & ~is_cmd & cmd_done & ~rd_q;
  assign tx_load = cmd_byte_done ? dec_rd : (byte_done & cmd_done & rd_q);

  serctl_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(addr_q), .wr_data(byte_val),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  serctl_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fall(fall), .load(tx_load),
    .load_data(rd_data), .order(order), .sdo_q(sdo_q)
  );

  assign sdo_oe = ~cs_n & cmd_done & rd_q;
  assign sdo    = sdo_oe ? sdo_q : 1'b0;

  assert_oe_after_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(cmd_byte_done));

  assert_cmd_held_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !cs_n) |=> $stable(addr_q));
endmodule

// File: tb/serctl_port_test.sv
module serctl_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msb_first = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo, sdo_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  serctl_port uut (
    .clk(clk), .rst_n(rst_n), .msb_first(msb_first), .cs_n(cs_n),
    .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act,
                     input logic [7:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] mk_cmd(input bit rd, input logic [2:0] a, input bit msb);
    return msb ? {rd, 4'b1010, a} : {a, 4'b0101, rd};
  endfunction

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 0; i < 8; i++) begin
      int idx;
      idx = msb_first ? 7 - i : i;
      sclk = 1'b0;
      sdi  = tx[idx];
      repeat (HALF) @(negedge clk);
      rx[idx] = sdo;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic open_win();
    sclk = 1'b0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic close_win();
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] junk;
    open_win();
    xfer(mk_cmd(1'b0, a, msb_first), junk);
    xfer(d, junk);
    close_win();
  endtask

  // driver: pushes the expectation, the received byte goes to the monitor
  task automatic rd_reg(input logic [2:0] a, input int n, input logic [7:0] expv,
                        input string tag);
    logic [7:0] r;
    open_win();
    xfer(mk_cmd(1'b1, a, msb_first), r);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(expv);
      tag_q.push_back(tag);
      xfer(8'h00, r);
      got_q.push_back(r);
    end
    close_win();
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0) begin
        logic [7:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(g == e, t, g, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] junk;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9 reset state
    chk(sdo_oe == 1'b0, "R9 oe after reset", {7'b0, sdo_oe}, 8'h00);
    chk(sdo == 1'b0, "R9 sdo after reset", {7'b0, sdo}, 8'h00);
    rd_reg(3'd6, 1, 8'h00, "R9 register resets to zero");

    // R1 R2 R3 R4 lsb-first write/read
    msb_first = 1'b0;
    wr_reg(3'd3, 8'hA5);
    rd_reg(3'd3, 1, 8'hA5, "R3 R4 lsb-first round trip");

    // msb-first
    msb_first = 1'b1;
    wr_reg(3'd5, 8'h3C);
    rd_reg(3'd5, 1, 8'h3C, "R1 R2 msb-first round trip");
    rd_reg(3'd3, 1, 8'hA5, "R2 msb read of lsb-written reg");
    msb_first = 1'b0;
    rd_reg(3'd5, 1, 8'h3C, "R2 lsb read of msb-written reg");

    // R5 enable behaviour
    open_win();
    chk(sdo_oe == 1'b0, "R5 oe low before command", {7'b0, sdo_oe}, 8'h00);
    xfer(mk_cmd(1'b1, 3'd3, 1'b0), junk);
    chk(sdo_oe == 1'b1, "R5 oe high after read command", {7'b0, sdo_oe}, 8'h01);
    close_win();
    chk(sdo_oe == 1'b0, "R5 oe low after cs high", {7'b0, sdo_oe}, 8'h00);
    chk(sdo == 1'b0, "R5 sdo low when disabled", {7'b0, sdo}, 8'h00);
    open_win();
    xfer(mk_cmd(1'b0, 3'd0, 1'b0), junk);
    chk(sdo_oe == 1'b0, "R5 oe low in write window", {7'b0, sdo_oe}, 8'h00);
    close_win();

    // R6 multi-byte windows
    open_win();
    xfer(mk_cmd(1'b0, 3'd2, 1'b0), junk);
    xfer(8'h11, junk);
    xfer(8'h22, junk);
    close_win();
    rd_reg(3'd2, 3, 8'h22, "R6 repeated write last wins, repeated read");
    rd_reg(3'd1, 1, 8'h00, "R6 neighbour untouched");

    // R7 command-looking data byte is just data
    msb_first = 1'b1;
    open_win();
    xfer(mk_cmd(1'b0, 3'd1, 1'b1), junk);
    xfer(mk_cmd(1'b1, 3'd4, 1'b1), junk);
    close_win();
    rd_reg(3'd1, 1, mk_cmd(1'b1, 3'd4, 1'b1), "R7 second byte stored as data");
    rd_reg(3'd4, 1, 8'h00, "R7 no command taken mid-window");
    msb_first = 1'b0;

    // R8 partial byte dropped
    open_win();
    xfer(mk_cmd(1'b0, 3'd2, 1'b0), junk);
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b0; sdi = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    close_win();
    rd_reg(3'd2, 1, 8'h22, "R8 partial byte discarded");

    // every entry
    for (int a = 0; a < 8; a++) wr_reg(3'(a), 8'(8'h40 + a * 8'h13));
    for (int a = 0; a < 8; a++) rd_reg(3'(a), 1, 8'(8'h40 + a * 8'h13), "R3 all entries");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule